// File: doc/BRIEF.md
# 64-bit Integer Execute Unit

This combinational unit forms the integer result of one RV64I base instruction in the execute stage of a pipeline. The decoder supplies an operation code, the first source register value and either the second source register value or an already sign-extended immediate. For the two upper-immediate instructions it also supplies the raw 20-bit constant and the PC of the instruction. The unit returns one 64-bit value for write-back.

The unit has no internal state. A result is valid in the same cycle as its inputs. One adder serves add, subtract, both less-than compares and the PC-relative upper-immediate sum. One barrel shifter handles all three shift kinds: a left shift is done by reversing the bits, shifting right and reversing them back.

Top module: `rv64_alu`

## Requirements
- R1: With op_i = 0 (add), result_o equals rs1_i plus the second operand, modulo 2^64. The second operand is imm_i when use_imm_i = 1 and rs2_i when use_imm_i = 0. This operand choice applies to every operation from 0 to 9.
- R2: With op_i = 1 (subtract), result_o equals rs1_i minus the second operand, modulo 2^64.
- R3: With op_i = 2 (signed less-than), result_o is 1 when rs1_i is below the second operand as two's-complement numbers, and 0 otherwise. Bits 63:1 are always 0.
- R4: With op_i = 3 (unsigned less-than), result_o is 1 when rs1_i is below the second operand as unsigned numbers, and 0 otherwise. Bits 63:1 are always 0.
- R5: op_i = 4, 5 and 6 give the bitwise AND, OR and XOR of rs1_i and the second operand.
- R6: With op_i = 7 (logical left shift), rs1_i is shifted left by the value of bits 5:0 of the second operand and the vacated bits are filled with 0. Bits 63:6 of the second operand have no effect.
- R7: With op_i = 8 (logical right shift), rs1_i is shifted right by bits 5:0 of the second operand and the vacated bits are filled with 0.
- R8: With op_i = 9 (arithmetic right shift), rs1_i is shifted right by bits 5:0 of the second operand. Every vacated bit takes the value of bit 63 of rs1_i.
- R9: With op_i = 10 (load upper immediate), result_o is upimm_i placed at bits 31:12, with bits 11:0 equal to 0 and bit 31 copied into bits 63:32. rs1_i, the second operand and pc_i have no effect.
- R10: With op_i = 11 (add upper immediate to PC), result_o is pc_i plus the R9 value, modulo 2^64.
- R11: With op_i = 12 to 15, result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code, using the encoding given in R1 to R11 |
| use_imm_i | input | 1 | 1 selects imm_i as the second operand, 0 selects rs2_i |
| rs1_i | input | 64 | First operand |
| rs2_i | input | 64 | Second register operand |
| imm_i | input | 64 | Sign-extended immediate operand |
| upimm_i | input | 20 | Raw constant for the upper-immediate operations |
| pc_i | input | 64 | PC of the instruction, used by operation 11 |
| result_o | output | 64 | Result |

## Verification
The bench runs every operation code over both operand sources and a grid of corner values: 0, 1, all ones, the largest positive value, the most negative value and alternating bit patterns. A compare that takes its result from the sign of the difference alone fails on the grid pairs whose difference overflows; the compare against the most negative value is one example. A compare that reads the carry with the wrong polarity inverts every unsigned answer. The bench then sweeps every shift amount from 0 to 127. A shifter that decodes bit 6 of the amount gives a wrong result for amounts of 64 and above. A right shift that fills from the wrong source fails on negative inputs. The upper-immediate cases use constants whose top bit is set, so a design that skips the extension from bit 31 produces wrong upper bits. If the operand select is wired backwards, every immediate-form check fails.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_SLT   = 4'd2,
    OP_SLTU  = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_SLL   = 4'd7,
    OP_SRL   = 4'd8,
    OP_SRA   = 4'd9,
    OP_LUI   = 4'd10,
    OP_AUIPC = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2
  } bw_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);

  localparam int MSB = XLEN - 1;

  logic [XLEN:0]   wide_sum;
  logic [XLEN-1:0] b_eff;
  logic            carry_out;
  logic            sign_differs;

  assign b_eff     = b_i ^ {XLEN{sub_i}};
  assign wide_sum  = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
  assign sum_o     = wide_sum[MSB:0];
  assign carry_out = wide_sum[XLEN];

  // a < b unsigned exactly when a - b borrows, i.e. no carry out
  assign lt_u_o = ~carry_out;

  // differing signs decide the signed order without looking at overflow
  assign sign_differs = a_i[MSB] ^ b_i[MSB];
  assign lt_s_o = sign_differs ? a_i[MSB] : wide_sum[MSB];

  always_comb begin
    if (sub_i && (b_i == '0)) begin
      a_r2_sub_zero_identity: assert (sum_o == a_i)
        else $error("subtracting zero changed the operand");
    end
    if (sub_i && (a_i == b_i)) begin
      a_r4_equal_not_less: assert (!lt_u_o && !lt_s_o)
        else $error("equal operands reported as less-than");
    end
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [XLEN-1:0] data_o
);

  localparam int MSB = XLEN - 1;

  function automatic logic [XLEN-1:0] bit_reverse(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    for (int k = 0; k < XLEN; k++) r[k] = v[MSB-k];
    return r;
  endfunction

  logic            fill_bit;
  logic [XLEN-1:0] stage [SHW+1];

  assign fill_bit = arith_i & ~left_i & data_i[MSB];
  assign stage[0] = left_i ? bit_reverse(data_i) : data_i;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stage[i+1] = amt_i[i] ? {{STEP{fill_bit}}, stage[i][MSB:STEP]} : stage[i];
  end

  assign data_o = left_i ? bit_reverse(stage[SHW]) : stage[SHW];

  always_comb begin
    if (amt_i == '0) begin
      a_r6_zero_amount_passes: assert (data_o == data_i)
        else $error("zero shift altered the data");
    end
    if (!left_i && (amt_i != '0)) begin
      a_r8_top_bit_fill: assert (data_o[MSB] == (arith_i & data_i[MSB]))
        else $error("right shift filled the top bit wrongly");
    end
    if (left_i && (amt_i != '0)) begin
      a_r6_low_bit_zero: assert (data_o[0] == 1'b0)
        else $error("left shift left a nonzero low bit");
    end
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  bw_sel_e         sel_i,
  output logic [XLEN-1:0] y_o
);

  always_comb begin
    unique case (sel_i)
      BW_AND:  y_o = a_i & b_i;
      BW_OR:   y_o = a_i | b_i;
      BW_XOR:  y_o = a_i ^ b_i;
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/rv64_alu.sv
module rv64_alu
  import alu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int UIMM_W = 20
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic              use_imm_i,
  input  logic [XLEN-1:0]   rs1_i,
  input  logic [XLEN-1:0]   rs2_i,
  input  logic [XLEN-1:0]   imm_i,
  input  logic [UIMM_W-1:0] upimm_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic [XLEN-1:0]   result_o
);

  localparam int SHW    = $clog2(XLEN);
  localparam int UP_LSB = 12;
  localparam int UP_TOP = UIMM_W + UP_LSB;
  localparam int EXT_W  = XLEN - UP_TOP;

  function automatic logic [XLEN-1:0] upper_value(input logic [UIMM_W-1:0] u);
    return {{EXT_W{u[UIMM_W-1]}}, u, {UP_LSB{1'b0}}};
  endfunction

  logic [XLEN-1:0] operand_b;
  logic [XLEN-1:0] up_val;
  logic            is_auipc;
  logic            do_sub;
  logic [XLEN-1:0] add_a, add_b, add_sum;
  logic            lt_s, lt_u;
  logic [XLEN-1:0] shift_out;
  logic            shift_left, shift_arith;
  bw_sel_e         bw_sel;
  logic [XLEN-1:0] bw_out;

  assign operand_b = use_imm_i ? imm_i : rs2_i;
  assign up_val    = upper_value(upimm_i);
  assign is_auipc  = (op_i == OP_AUIPC);
  assign do_sub    = (op_i == OP_SUB) || (op_i == OP_SLT) || (op_i == OP_SLTU);

  // one adder shared between register arithmetic and PC-relative sum
  assign add_a = is_auipc ? pc_i   : rs1_i;
  assign add_b = is_auipc ? up_val : operand_b;

  alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i    (add_a),
    .b_i    (add_b),
    .sub_i  (do_sub),
    .sum_o  (add_sum),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  assign shift_left  = (op_i == OP_SLL);
  assign shift_arith = (op_i == OP_SRA);

  alu_shifter #(.XLEN(XLEN), .SHW(SHW)) u_shifter (
    .data_i  (rs1_i),
    .amt_i   (operand_b[SHW-1:0]),
    .left_i  (shift_left),
    .arith_i (shift_arith),
    .data_o  (shift_out)
  );

  always_comb begin
    unique case (op_i)
      OP_OR:   bw_sel = BW_OR;
      OP_XOR:  bw_sel = BW_XOR;
      default: bw_sel = BW_AND;
    endcase
  end

  alu_bitwise #(.XLEN(XLEN)) u_bitwise (
    .a_i   (rs1_i),
    .b_i   (operand_b),
    .sel_i (bw_sel),
    .y_o   (bw_out)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB, OP_AUIPC:  result_o = add_sum;
      OP_SLT:                    result_o = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU:                   result_o = {{(XLEN-1){1'b0}}, lt_u};
      OP_AND, OP_OR, OP_XOR:     result_o = bw_out;
      OP_SLL, OP_SRL, OP_SRA:    result_o = shift_out;
      OP_LUI:                    result_o = up_val;
      default:                   result_o = '0;
    endcase
  end

  always_comb begin
    if ((op_i == OP_SLT) || (op_i == OP_SLTU)) begin
      a_r3_compare_upper_zero: assert (result_o[XLEN-1:1] == '0)
        else $error("compare result has nonzero upper bits");
    end
    if (op_i == OP_LUI) begin
      a_r9_lui_low_zero: assert (result_o[UP_LSB-1:0] == '0)
        else $error("upper immediate has nonzero low bits");
    end
    if (op_i == OP_AUIPC) begin
      a_r10_pc_low_kept: assert (result_o[UP_LSB-1:0] == pc_i[UP_LSB-1:0])
        else $error("PC-relative sum altered the low PC bits");
    end
    if (op_i > OP_AUIPC) begin
      a_r11_unused_code_zero: assert (result_o == '0)
        else $error("unused operation code gave a nonzero result");
    end
  end

endmodule

// File: tb/tb_rv64_alu.sv
module tb_rv64_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op;
  logic        use_imm;
  logic [63:0] rs1, rs2, imm, pc;
  logic [19:0] upimm;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rv64_alu dut (
    .op_i      (op),
    .use_imm_i (use_imm),
    .rs1_i     (rs1),
    .rs2_i     (rs2),
    .imm_i     (imm),
    .upimm_i   (upimm),
    .pc_i      (pc),
    .result_o  (result)
  );

  function automatic string req_tag(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      4'd10: return "R9";
      4'd11: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [3:0] o, input logic ui,
                                        input logic [63:0] a, input logic [63:0] r2,
                                        input logic [63:0] im, input logic [19:0] u,
                                        input logic [63:0] p);
    logic [63:0] b;
    logic [63:0] upv;
    int          sh;
    b   = ui ? im : r2;
    sh  = int'(b % 64);
    upv = 64'(signed'(u)) << 12;
    case (o)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      4'd3:  return (a < b) ? 64'd1 : 64'd0;
      4'd4:  return a & b;
      4'd5:  return a | b;
      4'd6:  return a ^ b;
      4'd7:  return a << sh;
      4'd8:  return a >> sh;
      4'd9:  return 64'($signed(a) >>> sh);
      4'd10: return upv;
      4'd11: return p + upv;
      default: return 64'd0;
    endcase
  endfunction

  task automatic apply_check(input logic [3:0] o, input logic ui, input logic [63:0] a,
                             input logic [63:0] r2, input logic [63:0] im,
                             input logic [19:0] u, input logic [63:0] p);
    logic [63:0] exp;
    @(posedge clk);
    op = o; use_imm = ui; rs1 = a; rs2 = r2; imm = im; upimm = u; pc = p;
    @(negedge clk);
    exp = model(o, ui, a, r2, im, u, p);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s op=%0d imm=%0d rs1=%h b=%h got=%h exp=%h",
               req_tag(o), o, ui, a, ui ? im : r2, result, exp);
    end
  endtask

  logic [63:0] vals [8];

  initial begin
    vals[0] = 64'h0000_0000_0000_0000;
    vals[1] = 64'h0000_0000_0000_0001;
    vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    vals[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    vals[4] = 64'h8000_0000_0000_0000;
    vals[5] = 64'h5555_5555_5555_5555;
    vals[6] = 64'hAAAA_AAAA_AAAA_AAAA;
    vals[7] = 64'h0000_0000_8000_0FC3;

    op = 4'd0; use_imm = 1'b0; rs1 = '0; rs2 = '0; imm = '0; upimm = '0; pc = '0;

    // reset state: all-zero inputs give a zero sum (R1)
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== 64'd0) begin
      fails++;
      $display("FAIL R1 reset-state got=%h exp=%h", result, 64'd0);
    end
    rst = 1'b0;

    // operation sweep over corner grid, both operand sources (R1..R11)
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int s = 0; s < 2; s++)
            apply_check(4'(o), 1'(s), vals[i], vals[j], vals[(j + 3) % 8],
                        vals[i][31:12] ^ vals[j][19:0], vals[(i + j) % 8] ^ 64'h1234);

    // shift amount sweep including amounts with bit 6 set (R6, R7, R8)
    for (int amt = 0; amt < 128; amt++)
      for (int o = 7; o < 10; o++)
        for (int s = 0; s < 2; s++)
          apply_check(4'(o), 1'(s), 64'hC123_4567_89AB_CDEF ^ (64'(amt) << 20),
                      s ? 64'hDEAD_0000_0000_0000 : 64'(amt),
                      s ? 64'(amt) : 64'h0BAD_0000_0000_0000,
                      20'h0, 64'h0);

    // upper immediate with top bit set, other inputs noisy (R9, R10)
    apply_check(4'd10, 1'b1, 64'hFFFF_0000_1111_2222, 64'h3, 64'h4, 20'h80001, 64'h9999);
    apply_check(4'd11, 1'b0, 64'h5, 64'h6, 64'h7, 20'hFFFFF, 64'h0000_0000_0000_1000);
    apply_check(4'd11, 1'b1, 64'h5, 64'h6, 64'h7, 20'h7FFFF, 64'hFFFF_FFFF_FFFF_FFF0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule